// File: doc/BRIEF.md
# Trace Output Configuration Register Bank

This block is the software-visible setup and status bank of a trace output unit. A host reaches it over a plain 32-bit bus: a word address, a write strobe, write data, and read data that follows the address in the same cycle. Writes take effect on the next clock edge. The bank holds the selected port width, the baud prescaler for the asynchronous output, the output protocol, the formatter controls and a 4-bit claim tag that debug agents use to mark ownership. It also answers a set of constant identification and status words.

The prescaler, the protocol and the formatter enables are driven straight out to the serializer. While the parallel port protocol is selected, the formatter is forced on. The formatter control word then reads back as its fixed default, whatever value is stored. When a serial protocol is chosen again, the stored value reappears. Two offsets have a different function for reads and for writes: one reads the claim mask and sets claim bits on a write, the other reads the claim tag and clears claim bits on a write.

Top module: `trace_cfg_regs`

## Requirements
- R1: After reset, the port-size word reads 0x1, the prescaler reads 0, the protocol reads 1, the formatter control reads 0x102 and the claim tag reads 0. The outputs port_size_o=1, prescaler_o=0, protocol_o=1, fmt_cont_o=1 and trig_ins_o=1.
- R2: Word addresses are byte offsets divided by 4. These words are constant: 0x000 (word 0x000) reads 0xB, 0x300 (word 0x0C0) reads 0x8, 0x308 (word 0x0C2) reads 0, and 0xFC8 (word 0x3F2) reads 0xCA1 when HAS_ITRACE=1 and 0xCA0 otherwise.
- R3: A write to offset 0x010 (word 0x004) stores wdata[12:0] as the prescaler. Reads return it with bits 31:13 at zero, and prescaler_o carries it.
- R4: A write to offset 0x004 (word 0x001) stores wdata[3:0] as the port-size selection. Reads return it with the upper bits at zero, and port_size_o carries it.
- R5: A write to offset 0x0F0 (word 0x03C) stores wdata[1:0] as the protocol (0 parallel, 1 serial Manchester, 2 serial NRZ). Reads return it zero-extended, and protocol_o carries it.
- R6: A write to offset 0x304 (word 0x0C1) stores wdata[8] (trigger insert) and wdata[1] (continuous formatting). In a serial protocol, reads return those two bits in place with all other bits zero.
- R7: While the protocol is 0, a read of 0x304 returns 0x102 and fmt_cont_o=trig_ins_o=1. A write to 0x304 in that mode is still stored, and it shows once a nonzero protocol is selected.
- R8: A read of offset 0xFA0 (word 0x3E8) returns 0xF. A write there sets each claim bit i (i<4) whose wdata[i] is 1 and keeps the rest.
- R9: A read of offset 0xFA4 (word 0x3E9) returns the 4-bit claim tag, zero-extended. A write there clears each claim bit i (i<4) whose wdata[i] is 1.
- R10: Writes to the constant words and to unlisted addresses change no readable value. Reads of unlisted addresses return 0.
- R11: Reads are combinational. A read in the same cycle as a write to that word returns the value from before the write, and the new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 10 | Word address (byte offset / 4) |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| port_size_o | output | 4 | Selected port-width one-hot code |
| prescaler_o | output | 13 | Baud prescaler (divisor minus one) |
| protocol_o | output | 2 | Output protocol |
| fmt_cont_o | output | 1 | Effective continuous-formatting enable |
| trig_ins_o | output | 1 | Effective trigger-insert enable |

## Verification
Two functions can act in the same cycle: a write, and the combinational readback of the word being written. The bench issues every write with the read address on the target word and checks that rdata_o still shows the old value. It then checks that the new value appears on the next cycle. The protocol override and the formatter store can also meet: a write to the formatter control word is made while parallel mode is active. The bench checks that the readback stays 0x102, then selects a serial protocol and checks that the written value now reads back.

// File: rtl/trace_cfg_pkg.sv
package trace_cfg_pkg;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_PSIZE_SUP = 10'h000;
  localparam logic [ADDR_W-1:0] A_PSIZE_CUR = 10'h001;
  localparam logic [ADDR_W-1:0] A_PRESC     = 10'h004;
  localparam logic [ADDR_W-1:0] A_PROTO     = 10'h03C;
  localparam logic [ADDR_W-1:0] A_FMT_STAT  = 10'h0C0;
  localparam logic [ADDR_W-1:0] A_FMT_CTRL  = 10'h0C1;
  localparam logic [ADDR_W-1:0] A_SYNC_CNT  = 10'h0C2;
  localparam logic [ADDR_W-1:0] A_CLAIM_SET = 10'h3E8;
  localparam logic [ADDR_W-1:0] A_CLAIM_CLR = 10'h3E9;
  localparam logic [ADDR_W-1:0] A_DEV_ID    = 10'h3F2;

  localparam logic [DATA_W-1:0] PSIZE_SUP_VAL = 32'h0000_000B;
  localparam logic [DATA_W-1:0] FMT_STAT_VAL  = 32'h0000_0008;
  localparam logic [DATA_W-1:0] FMT_FORCED    = 32'h0000_0102;

  typedef enum logic [1:0] {
    PROTO_PARALLEL   = 2'd0,
    PROTO_MANCHESTER = 2'd1,
    PROTO_NRZ        = 2'd2,
    PROTO_RSVD       = 2'd3
  } proto_e;
endpackage

// File: rtl/trace_cfg_ctrl.sv
module trace_cfg_ctrl
  import trace_cfg_pkg::*;
#(
  parameter int unsigned PSIZE_W = 4,
  parameter int unsigned PRESC_W = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_psize_i,
  input  logic               wr_presc_i,
  input  logic               wr_proto_i,
  input  logic               wr_fmt_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [PSIZE_W-1:0] psize_o,
  output logic [PRESC_W-1:0] presc_o,
  output proto_e             proto_o,
  output logic               fmt_trig_o,
  output logic               fmt_cont_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psize_o    <= PSIZE_W'(1);
      presc_o    <= '0;
      proto_o    <= PROTO_MANCHESTER;
      fmt_trig_o <= 1'b1;
      fmt_cont_o <= 1'b1;
    end else begin
      if (wr_psize_i) psize_o <= wdata_i[PSIZE_W-1:0];
      if (wr_presc_i) presc_o <= wdata_i[PRESC_W-1:0];
      if (wr_proto_i) proto_o <= proto_e'(wdata_i[1:0]);
      if (wr_fmt_i) begin
        fmt_trig_o <= wdata_i[8];
        fmt_cont_o <= wdata_i[1];
      end
    end
  end

  a_r3_presc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_presc_i |=> $stable(presc_o));
  a_r5_proto_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_proto_i |=> proto_o == proto_e'($past(wdata_i[1:0])));
endmodule

// File: rtl/trace_cfg_claim.sv
module trace_cfg_claim
  import trace_cfg_pkg::*;
#(
  parameter int unsigned CLAIM_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic               clr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [CLAIM_W-1:0] tag_o
);
  for (genvar i = 0; i < CLAIM_W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      tag_o[i] <= 1'b0;
      else if (set_i && wdata_i[i])     tag_o[i] <= 1'b1;
      else if (clr_i && wdata_i[i])     tag_o[i] <= 1'b0;
    end
  end

  a_r8_claim_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> tag_o == ($past(tag_o) | $past(wdata_i[CLAIM_W-1:0])));
  a_r9_claim_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> tag_o == ($past(tag_o) & ~$past(wdata_i[CLAIM_W-1:0])));
  a_r10_claim_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i || clr_i) |=> $stable(tag_o));
endmodule

// File: rtl/trace_cfg_regs.sv
module trace_cfg_regs
  import trace_cfg_pkg::*;
#(
  parameter bit          HAS_ITRACE = 1'b0,
  parameter int unsigned PSIZE_W    = 4,
  parameter int unsigned PRESC_W    = 13,
  parameter int unsigned CLAIM_W    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [PSIZE_W-1:0] port_size_o,
  output logic [PRESC_W-1:0] prescaler_o,
  output logic [1:0]         protocol_o,
  output logic               fmt_cont_o,
  output logic               trig_ins_o
);
  localparam logic [DATA_W-1:0] DEV_ID_VAL  = HAS_ITRACE ? 32'h0000_0CA1 : 32'h0000_0CA0;
  localparam logic [DATA_W-1:0] CLAIM_MASK  = DATA_W'((1 << CLAIM_W) - 1);

  logic [PSIZE_W-1:0] psize;
  logic [PRESC_W-1:0] presc;
  proto_e             proto;
  logic               st_trig, st_cont;
  logic [CLAIM_W-1:0] claim;
  logic               parallel;
  logic [DATA_W-1:0]  fmt_rd;

  trace_cfg_ctrl #(.PSIZE_W(PSIZE_W), .PRESC_W(PRESC_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_psize_i (we_i && addr_i == A_PSIZE_CUR),
    .wr_presc_i (we_i && addr_i == A_PRESC),
    .wr_proto_i (we_i && addr_i == A_PROTO),
    .wr_fmt_i   (we_i && addr_i == A_FMT_CTRL),
    .wdata_i    (wdata_i),
    .psize_o    (psize),
    .presc_o    (presc),
    .proto_o    (proto),
    .fmt_trig_o (st_trig),
    .fmt_cont_o (st_cont)
  );

  trace_cfg_claim #(.CLAIM_W(CLAIM_W)) u_claim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (we_i && addr_i == A_CLAIM_SET),
    .clr_i   (we_i && addr_i == A_CLAIM_CLR),
    .wdata_i (wdata_i),
    .tag_o   (claim)
  );

  // parallel port forces the formatter on and masks the stored control
  assign parallel = (proto == PROTO_PARALLEL);
  assign fmt_rd   = parallel ? FMT_FORCED
                             : (DATA_W'(st_trig) << 8) | (DATA_W'(st_cont) << 1);

  always_comb begin
    unique case (addr_i)
      A_PSIZE_SUP: rdata_o = PSIZE_SUP_VAL;
      A_PSIZE_CUR: rdata_o = DATA_W'(psize);
      A_PRESC:     rdata_o = DATA_W'(presc);
      A_PROTO:     rdata_o = DATA_W'(proto);
      A_FMT_STAT:  rdata_o = FMT_STAT_VAL;
      A_FMT_CTRL:  rdata_o = fmt_rd;
      A_SYNC_CNT:  rdata_o = '0;
      A_CLAIM_SET: rdata_o = CLAIM_MASK;
      A_CLAIM_CLR: rdata_o = DATA_W'(claim);
      A_DEV_ID:    rdata_o = DEV_ID_VAL;
      default:     rdata_o = '0;
    endcase
  end

  assign port_size_o = psize;
  assign prescaler_o = presc;
  assign protocol_o  = proto;
  assign fmt_cont_o  = parallel | st_cont;
  assign trig_ins_o  = parallel | st_trig;

  a_r7_fmt_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (protocol_o == 2'd0 && addr_i == A_FMT_CTRL) |-> rdata_o == 32'h102);
  a_r7_fmt_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    protocol_o == 2'd0 |-> (fmt_cont_o && trig_ins_o));
  a_r11_fmt_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_FMT_CTRL && protocol_o != 2'd0) |=>
      (protocol_o != 2'd0) |-> (trig_ins_o == $past(wdata_i[8]) && fmt_cont_o == $past(wdata_i[1])));
endmodule

// File: tb/trace_cfg_regs_test.sv
module trace_cfg_regs_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  port_size;
  logic [12:0] prescaler;
  logic [1:0]  protocol;
  logic        fmt_cont, trig_ins;

  int unsigned n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [3:0]  m_psize;
  logic [12:0] m_presc;
  logic [1:0]  m_proto;
  logic [31:0] m_fmt;
  logic [3:0]  m_claim;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_cfg_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .port_size_o(port_size), .prescaler_o(prescaler),
    .protocol_o(protocol), .fmt_cont_o(fmt_cont), .trig_ins_o(trig_ins)
  );

  localparam logic [9:0] LISTED [10] = '{10'h000, 10'h001, 10'h004, 10'h03C, 10'h0C0,
                                         10'h0C1, 10'h0C2, 10'h3E8, 10'h3E9, 10'h3F2};

  function automatic logic [31:0] exp_read(logic [9:0] a);
    case (a)
      10'h000: return 32'hB;
      10'h001: return {28'h0, m_psize};
      10'h004: return {19'h0, m_presc};
      10'h03C: return {30'h0, m_proto};
      10'h0C0: return 32'h8;
      10'h0C1: return (m_proto == 2'd0) ? 32'h102 : m_fmt;
      10'h0C2: return 32'h0;
      10'h3E8: return 32'hF;
      10'h3E9: return {28'h0, m_claim};
      10'h3F2: return 32'hCA0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_write(logic [9:0] a, logic [31:0] d);
    case (a)
      10'h001: m_psize = d[3:0];
      10'h004: m_presc = d[12:0];
      10'h03C: m_proto = d[1:0];
      10'h0C1: m_fmt   = d & 32'h102;
      10'h3E8: m_claim = m_claim | d[3:0];
      10'h3E9: m_claim = m_claim & ~d[3:0];
      default: ;
    endcase
  endtask

  // write with readback of the target word in the same cycle (R11)
  task automatic wr(logic [9:0] a, logic [31:0] d, string req);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    #1 check({"R11 old value during write / ", req}, rdata, exp_read(a));
    @(negedge clk);
    we = 1'b0;
    model_write(a, d);
    #1 check(req, rdata, exp_read(a));
  endtask

  task automatic rd(logic [9:0] a, string req);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 check(req, rdata, exp_read(a));
  endtask

  task automatic check_outputs(string req);
    check({req, " port_size_o"}, {28'h0, port_size}, {28'h0, m_psize});
    check({req, " prescaler_o"}, {19'h0, prescaler}, {19'h0, m_presc});
    check({req, " protocol_o"},  {30'h0, protocol},  {30'h0, m_proto});
    check({req, " fmt_cont_o"},  {31'h0, fmt_cont},  {31'h0, (m_proto == 2'd0) | m_fmt[1]});
    check({req, " trig_ins_o"},  {31'h0, trig_ins},  {31'h0, (m_proto == 2'd0) | m_fmt[8]});
  endtask

  task automatic read_all(string req);
    foreach (LISTED[i]) rd(LISTED[i], req);
  endtask

  initial begin
    void'($urandom(32'd20481));
    m_psize = 4'h1; m_presc = '0; m_proto = 2'd1; m_fmt = 32'h102; m_claim = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2 constants
    rd(10'h001, "R1 port size reset");
    rd(10'h004, "R1 prescaler reset");
    rd(10'h03C, "R1 protocol reset");
    rd(10'h0C1, "R1 fmt ctrl reset");
    rd(10'h3E9, "R1 claim reset");
    check_outputs("R1");
    rd(10'h000, "R2 supported sizes");
    rd(10'h0C0, "R2 fmt status");
    rd(10'h0C2, "R2 sync counter");
    rd(10'h3F2, "R2 device id");

    // R3 R4 R5 R6 directed
    wr(10'h004, 32'hFFFF_FFFF, "R3 prescaler max, upper bits dropped");
    wr(10'h004, 32'h0000_0A5A, "R3 prescaler pattern");
    wr(10'h001, 32'hFFFF_FFF4, "R4 port size");
    wr(10'h0C1, 32'hFFFF_FFFF, "R6 fmt bits 8 and 1 only");
    wr(10'h0C1, 32'h0000_0100, "R6 fmt trig only");
    check_outputs("R6");
    wr(10'h03C, 32'hFFFF_FFFE, "R5 protocol nrz");
    check_outputs("R5");

    // R7 parallel override with a store during override
    wr(10'h03C, 32'h0, "R7 select parallel");
    rd(10'h0C1, "R7 forced readback");
    check_outputs("R7 parallel");
    wr(10'h0C1, 32'h0000_0002, "R7 write during parallel, readback forced");
    wr(10'h03C, 32'h1, "R7 back to serial");
    rd(10'h0C1, "R7 stored value shows");
    check_outputs("R7 serial");

    // R8 R9 claim tag
    wr(10'h3E8, 32'hFFFF_FFF5, "R8 claim set");
    rd(10'h3E9, "R8 claim after set");
    wr(10'h3E8, 32'h0000_0002, "R8 claim set more");
    rd(10'h3E9, "R8 claim accumulates");
    wr(10'h3E9, 32'hFFFF_FFF4, "R9 claim clear");
    rd(10'h3E8, "R8 mask unchanged");

    // R10 read-only and unlisted writes
    wr(10'h000, 32'hDEAD_BEEF, "R10 write to constant word");
    wr(10'h3F2, 32'h0, "R10 write to device id");
    wr(10'h123, 32'hFFFF_FFFF, "R10 write unlisted");
    read_all("R10 state unchanged");

    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [9:0]  a;
      logic [31:0] d;
      if ($urandom_range(3) == 0) a = 10'($urandom);
      else a = LISTED[$urandom_range(9)];
      d = $urandom;
      if ($urandom_range(1) == 0) wr(a, d, "R10 random write");
      else rd(a, "R10 random read");
      if (k % 25 == 0) begin
        check_outputs("R3 R4 R5 R7 random outputs");
        read_all("R6 R8 R9 random sweep");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule